// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit device address into a physical address by reading a two-level translation table in memory. A TLB-side requester presents an address that missed. The walker first fetches a first-level descriptor from the table whose base address is given on `tbl_base`. Depending on the kind of that descriptor, the walker either finishes at once with a 1 MB or 16 MB mapping, or fetches a second-level descriptor that maps a 4 KB or 64 KB page. It returns the physical address and a page-size code, or a fault with a status word.

The memory side is a single-beat read port. Requests use a valid/ready handshake and responses use a valid strobe. Only one walk is in flight at any time, and the walker goes back to idle after each result. When `walk_en` is low, every request ends as a fault and no memory is read.

Large mappings repeat in the tables. A 16 MB mapping fills 16 neighbouring first-level slots with the same word. A 64 KB mapping fills 16 neighbouring second-level slots with the same word. The walker therefore reads just the one slot that the address selects.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read goes to address `{tbl_base[31:14], va[31:20], 2'b00}`.
- R3: A first-level word with bits[1:0]=10 and bit 18 clear maps 1 MB. The result is `pa = {d[31:20], va[19:0]}` with `rsp_size` = 2. One memory read is made.
- R4: A first-level word with bits[1:0]=10 and bit 18 set maps 16 MB. The result is `pa = {d[31:24], va[23:0]}` with `rsp_size` = 3. All 16 replicated slots of a group give the same base.
- R5: A first-level word with bits[1:0]=01 points to a second-level table. The second read goes to `{d[31:10], va[19:12], 2'b00}`, and exactly two reads are made.
- R6: A second-level word with bit 1 set maps 4 KB. The result is `pa = {d[31:12], va[11:0]}` with `rsp_size` = 0.
- R7: A second-level word with bits[1:0]=01 maps 64 KB. The result is `pa = {d[31:16], va[15:0]}` with `rsp_size` = 1.
- R8: A first-level word with bits[1:0] of 00 or 11 gives a fault with status 4'b0001. It makes one read and no second read.
- R9: A second-level word with bits[1:0]=00 gives a fault with status 4'b0010.
- R10: A request taken while `walk_en` is 0 gives a fault with status 4'b0100 on the next cycle. No memory read is made.
- R11: Every response carries the requested address on `rsp_va`. A fault drives `rsp_pa` = 0 and `rsp_size` = 0. `rsp_valid` is a one-cycle pulse. `req_ready` is low from acceptance until the response has been given.
- R12: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_en | input | 1 | Enables table walking; when low, requests fault |
| tbl_base | input | 32 | First-level table base, 16 KB aligned |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_addr | input | 32 | Device address to translate |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_status | output | 4 | Fault status (0001 first level, 0010 second level, 0100 walking off) |
| rsp_va | output | 32 | Device address of this result |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_size | output | 2 | Page size: 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word read |

## Verification
The bench builds the walker with its default fault codes. Its memory model holds a synthetic table in which every one of the 4096 first-level slots is defined, so a sweep that touches each slot covers all descriptor kinds. That sweep includes a full 256-slot second-level table and every 16-slot replicated group of the 16 MB region. The memory model varies its request-ready timing and its read latency, which exercises stalls on both read stages.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter logic [3:0] FLT_L1  = 4'b0001,
  parameter logic [3:0] FLT_L2  = 4'b0010,
  parameter logic [3:0] FLT_OFF = 4'b0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        walk_en,
  input  logic [31:0] tbl_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [3:0]  rsp_status,
  output logic [31:0] rsp_va,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_size,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);

  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE} st_t;

  st_t         st;
  logic [31:0] va_q;
  logic [21:0] l2_base_q;
  logic [31:0] d;

  assign d             = mem_rsp_data;
  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_DONE);
  assign rsp_fault     = |rsp_status;
  assign rsp_va        = va_q;
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_req_addr  = (st == S_L2_REQ) ? {l2_base_q, va_q[19:12], 2'b00}
                                          : {tbl_base[31:14], va_q[31:20], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      l2_base_q  <= '0;
      rsp_pa     <= '0;
      rsp_size   <= '0;
      rsp_status <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q     <= req_addr;
          rsp_pa   <= '0;
          rsp_size <= '0;
          if (walk_en) begin
            rsp_status <= '0;
            st         <= S_L1_REQ;
          end else begin
            rsp_status <= FLT_OFF;
            st         <= S_DONE;
          end
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          case (d[1:0])
            2'b01: begin
              l2_base_q <= d[31:10];
              st        <= S_L2_REQ;
            end
            2'b10: begin
              if (d[18]) begin
                rsp_pa   <= {d[31:24], va_q[23:0]};
                rsp_size <= 2'd3;
              end else begin
                rsp_pa   <= {d[31:20], va_q[19:0]};
                rsp_size <= 2'd2;
              end
              st <= S_DONE;
            end
            default: begin
              rsp_status <= FLT_L1;
              st         <= S_DONE;
            end
          endcase
        end
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (d[1]) begin
            rsp_pa   <= {d[31:12], va_q[11:0]};
            rsp_size <= 2'd0;
          end else if (d[0]) begin
            rsp_pa   <= {d[31:16], va_q[15:0]};
            rsp_size <= 2'd1;
          end else begin
            rsp_status <= FLT_L2;
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_off_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !walk_en) |=> (rsp_valid && rsp_fault && !mem_req_valid));

  a_r11_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == 32'd0 && rsp_size == 2'd0));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_en = 1'b1;
  logic [31:0] tbl_base = 32'h0010_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_fault;
  logic [3:0]  rsp_status;
  logic [31:0] rsp_va, rsp_pa;
  logic [1:0]  rsp_size;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int total = 0;
  int bad = 0;
  int reads = 0;
  int cyc = 0;
  int hold_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n), .walk_en(walk_en), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_status(rsp_status),
    .rsp_va(rsp_va), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  function automatic logic [31:0] l1d(input logic [11:0] i);
    logic [31:0] r;
    r = '0;
    if (i[11:8] == 4'h1) begin
      r[31:24] = i[11:4] ^ 8'h5A;
      r[18]    = 1'b1;
      r[1:0]   = 2'b10;
    end else begin
      case (i[1:0])
        2'd0: r = '0;
        2'd1: begin r[31:20] = i ^ 12'hA5C; r[1:0] = 2'b10; end
        2'd2: r = 32'h0800_0000 + ({20'd0, i} << 10) + 32'd1;
        default: r = {i, 20'h0} | 32'd3;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] l2d(input logic [11:0] t, input logic [7:0] j);
    logic [31:0] r;
    r = '0;
    if (j[7:6] == 2'b01) begin
      r[31:16] = {t, j[7:4]};
      r[1:0]   = 2'b01;
    end else begin
      case (j[1:0])
        2'd1: begin r[31:12] = {t, j}; r[1:0] = 2'b10; end
        2'd2: begin r[31:12] = {t, j}; r[1:0] = 2'b11; end
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] mem_at(input logic [31:0] a);
    if (a[31:14] == tbl_base[31:14]) return l1d(a[13:2]);
    if (a[31:24] == 8'h08) return l2d(a[21:10], a[9:2]);
    return 32'hDEAD_BEEF;
  endfunction

  logic        pend = 1'b0;
  logic [31:0] paddr = '0;
  logic [1:0]  dly = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      pend <= 1'b0;
      mem_req_ready <= 1'b0;
      mem_rsp_data <= '0;
    end else begin
      mem_req_ready <= cyc[0] | cyc[2];
      if (mem_req_valid && mem_req_ready && !pend) begin
        pend  <= 1'b1;
        paddr <= mem_req_addr;
        dly   <= 2'(cyc[3:2]);
        reads <= reads + 1;
      end else if (pend) begin
        if (dly == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem_at(paddr);
          pend <= 1'b0;
        end else dly <= dly - 2'd1;
      end
    end
  end

  logic        pv = 1'b0;
  logic [31:0] pa_prev = '0;
  always @(negedge clk) begin
    if (rst_n && pv && (!mem_req_valid || mem_req_addr != pa_prev)) hold_bad <= hold_bad + 1;
    pv      <= rst_n && mem_req_valid && !mem_req_ready;
    pa_prev <= mem_req_addr;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic en);
    logic [11:0] i;
    logic [31:0] e1, e2, epa;
    logic [1:0]  esz;
    logic [3:0]  est;
    int          ereads, r0, guard;
    string       rq;
    i = va[31:20];
    e1 = l1d(i);
    epa = '0; esz = 2'd0; est = 4'd0; ereads = 1;
    if (!en) begin
      est = 4'b0100; ereads = 0; rq = "R10";
    end else if (e1[1:0] == 2'b01) begin
      ereads = 2;
      e2 = l2d(i, va[19:12]);
      if (e2[1]) begin epa = {e2[31:12], va[11:0]}; esz = 2'd0; rq = "R6"; end
      else if (e2[0]) begin epa = {e2[31:16], va[15:0]}; esz = 2'd1; rq = "R7"; end
      else begin est = 4'b0010; rq = "R9"; end
    end else if (e1[1:0] == 2'b10) begin
      if (e1[18]) begin epa = {e1[31:24], va[23:0]}; esz = 2'd3; rq = "R4"; end
      else begin epa = {e1[31:20], va[19:0]}; esz = 2'd2; rq = "R3"; end
    end else begin
      est = 4'b0001; rq = "R8";
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; walk_en = en;
    r0 = reads;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready || rsp_valid, "R11 busy", {63'd0, req_ready}, 64'd0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    if (!en) chk(guard == 0, "R10 latency", 64'(guard), 64'd0);
    chk(rsp_valid && rsp_status == est && rsp_fault == (est != 0), rq,
        {59'd0, rsp_valid, rsp_status}, {59'd1, est});
    chk(rsp_pa == epa && rsp_size == esz, rq, {30'd0, rsp_size, rsp_pa}, {30'd0, esz, epa});
    chk(rsp_va == va, "R11 va", {32'd0, rsp_va}, {32'd0, va});
    chk(reads - r0 == ereads, ereads == 2 ? "R5 reads" : "R2 reads", 64'(reads - r0), 64'(ereads));
    @(negedge clk);
    chk(!rsp_valid, "R11 pulse", {63'd0, rsp_valid}, 64'd0);
  endtask

  always @(negedge clk) begin
    if (!done && cyc > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
    for (int i = 0; i < 4096; i++)
      walk({12'(i), 8'(i * 37), 12'(i * 5 + 3)}, 1'b1);
    for (int j = 0; j < 256; j++)
      walk({12'd2, 8'(j), 12'hFFF ^ 12'(j)}, 1'b1);
    for (int k = 0; k < 16; k++)
      walk({12'h130 + 12'(k), 20'h5_A5A5}, 1'b1);
    for (int k = 0; k < 16; k++)
      walk({12'(k * 251), 20'(k * 7919)}, 1'b0);
    walk(32'h0021_3456, 1'b1);
    chk(hold_bad == 0, "R12 hold", 64'(hold_bad), 64'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule